// File: doc/BRIEF.md
# Interval Timer and Interrupt Register Block

This block is a byte-wide file of sixteen registers for a host processor. It holds two data port bytes, two direction bytes, a shift byte, an auxiliary control byte, a peripheral control byte and a second port A byte. It also has two 16-bit down counters and an interrupt flag and enable pair. The register is chosen by four address bits starting at bit 9, so the host can map the block with a 512-byte stride between registers. Reads return data in the same cycle from a combinational mux. Any read side effect takes place at the clock edge that ends the access.

Timer 1 reloads from its 16-bit latch. When auxiliary control bits 7:6 hold 01, it counts down on each tick through 0 and 0xFFFF, then reloads. This gives one flag every latch+2 ticks. Timer 2 is a one-shot counter. It keeps decrementing and wrapping, but it raises its flag only on the first underflow after a load. An external shift engine reports a completed byte with a one-cycle strobe, and that strobe sets the shift flag. The single interrupt line combines the enabled timer 1 and shift flags. The timer 2 flag is visible to polling but is left out of the line.

Top module: `tmr_irq_regs`

## Requirements
- R1: After reset every register reads 0, except the timer 1 counter and latch bytes (indices 4 to 7), which read 0xFF, the timer 2 counter bytes (indices 8 and 9), which read 0xFF, and the enable register (index 14), which reads 0x80. irq_o is low.
- R2: The register index is addr_i[12:9]. The plain storage registers are 0 port B, 1 port A, 2 dir B, 3 dir A, 10 shift, 11 auxiliary, 12 peripheral and 15 port A without handshake. Each returns the last byte written to it, whatever the other address bits are.
- R3: Reading index 13 returns the flag bits 6:0, with bit 7 set when any flag is also enabled. The flag positions are: bit 2 shift, bit 5 timer 2, bit 6 timer 1.
- R4: A write to index 14 with bit 7 set ORs bits 6:0 into the enables. With bit 7 clear, it clears each enable whose bit is 1. A read of index 14 returns the enables with bit 7 forced to 1.
- R5: A write to index 13 clears every flag whose data bit is 1 and leaves the others unchanged.
- R6: irq_o is high exactly when flag bit 6 or flag bit 2 is set together with its enable. The timer 2 flag never drives irq_o.
- R7: A read of index 4 clears the timer 1 flag, a read of index 8 clears the timer 2 flag, and a read of index 10 clears the shift flag.
- R8: A write to index 5 loads the latch high byte, loads the timer 1 counter from {data, latch low}, and clears the timer 1 flag. A write to index 7 loads the latch high byte and clears the flag without touching the counter. Writes to index 4 or 6 change only the latch low byte.
- R9: With auxiliary bits 7:6 = 01, after a counter load of value N the first timer 1 flag comes after N+1 ticks. Each later flag comes latch+2 ticks after the previous one.
- R10: With auxiliary bits 7:6 other than 01, timer 1 decrements through 0xFFFF to 0xFFFE without reloading, and it sets no flag.
- R11: A write to index 8 stores a low byte and loads the timer 2 counter with that byte zero-extended. A write to index 9 loads the counter with {data, stored low byte}.
- R12: Timer 2 decrements once per tick and wraps from 0 to 0xFFFF. Its flag is set on the first wrap after a load and on no later wrap.
- R13: A pulse on sr_event_i sets the shift flag. If the same cycle also clears that flag, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer count enable, one tick per high cycle |
| sr_event_i | input | 1 | Shift-byte-complete strobe from the shift engine |
| cs_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (13) | Byte address; bits 12:9 select the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 13-bit address and the register index at bit 9. Because ticks come only from the bench, small latch values let it sweep timer 1 periods for every latch from 0 to 15. It also sweeps timer 2 expiries for small counts. A single run of 65536 ticks takes timer 2 once around its full range, which shows that a second underflow raises no flag.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  localparam int BYTE_W = 8;
  localparam int TMR_W  = 2 * BYTE_W;
  localparam int FLG_W  = 7;
  localparam int NREG   = 16;

  typedef enum logic [3:0] {
    RI_PORTB = 4'd0,  RI_PORTA = 4'd1,  RI_DIRB  = 4'd2,  RI_DIRA  = 4'd3,
    RI_T1CL  = 4'd4,  RI_T1CH  = 4'd5,  RI_T1LL  = 4'd6,  RI_T1LH  = 4'd7,
    RI_T2L   = 4'd8,  RI_T2H   = 4'd9,  RI_SHIFT = 4'd10, RI_AUX   = 4'd11,
    RI_PERI  = 4'd12, RI_FLAG  = 4'd13, RI_ENA   = 4'd14, RI_PANH  = 4'd15
  } reg_idx_e;

  localparam int FB_SHIFT = 2;
  localparam int FB_T2    = 5;
  localparam int FB_T1    = 6;

  localparam logic [FLG_W-1:0] IRQ_MASK = FLG_W'((1 << FB_T1) | (1 << FB_SHIFT));

  function automatic logic is_plain(input logic [3:0] idx);
    case (idx)
      RI_PORTB, RI_PORTA, RI_DIRB, RI_DIRA,
      RI_SHIFT, RI_AUX, RI_PERI, RI_PANH: is_plain = 1'b1;
      default:                            is_plain = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_reload.sv
module tmr_reload
  import tmr_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cont_i,
  input  logic              lat_lo_we_i,
  input  logic              lat_hi_we_i,
  input  logic              load_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [TMR_W-1:0]  cnt_o,
  output logic [TMR_W-1:0]  latch_o,
  output logic              expire_o
);

  localparam logic [TMR_W-1:0] ALL1 = '1;

  logic [TMR_W-1:0] cnt_q, latch_q;

  // flag on the 0 -> -1 step; the -1 state makes the period latch+2
  assign expire_o = tick_i & cont_i & ~load_we_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= ALL1;
    end else begin
      if (lat_lo_we_i) latch_q[BYTE_W-1:0]     <= wdata_i;
      if (lat_hi_we_i) latch_q[TMR_W-1:BYTE_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ALL1;
    end else if (load_we_i) begin
      cnt_q <= {wdata_i, latch_q[BYTE_W-1:0]};
    end else if (tick_i) begin
      if (cont_i && cnt_q == ALL1) cnt_q <= latch_q;
      else                         cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;

endmodule

// File: rtl/tmr_oneshot.sv
module tmr_oneshot
  import tmr_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [TMR_W-1:0]  cnt_o,
  output logic              under_o
);

  logic [TMR_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] lo_q;
  logic              armed_q;
  logic              load;

  assign load    = lo_we_i | hi_we_i;
  assign under_o = tick_i & ~load & armed_q & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      lo_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (lo_we_i) begin
        lo_q    <= wdata_i;
        cnt_q   <= {{(TMR_W-BYTE_W){1'b0}}, wdata_i};
        armed_q <= 1'b1;
      end else if (hi_we_i) begin
        cnt_q   <= {wdata_i, lo_q};
        armed_q <= 1'b1;
      end else if (tick_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (under_o) armed_q <= 1'b0;
      end
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import tmr_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLG_W-1:0]  set_i,
  input  logic [FLG_W-1:0]  clr_i,
  input  logic              ena_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [FLG_W-1:0]  flags_o,
  output logic [FLG_W-1:0]  enables_o,
  output logic              irq_o
);

  logic [FLG_W-1:0] flg_q, ena_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
      ena_q <= '0;
    end else begin
      flg_q <= (flg_q & ~clr_i) | set_i;  // set beats clear
      if (ena_we_i) begin
        if (wdata_i[BYTE_W-1]) ena_q <= ena_q | wdata_i[FLG_W-1:0];
        else                   ena_q <= ena_q & ~wdata_i[FLG_W-1:0];
      end
    end
  end

  assign flags_o   = flg_q;
  assign enables_o = ena_q;
  assign irq_o     = |(flg_q & ena_q & IRQ_MASK);

endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sr_event_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);

  localparam int IDX_MSB = IDX_LSB + 3;

  logic [3:0]       reg_idx;
  logic             wr, rd;
  logic [BYTE_W-1:0] store_q [NREG];
  logic [TMR_W-1:0] t1_cnt, t1_latch, t2_cnt;
  logic             t1_cont, t1_exp, t2_under;
  logic [FLG_W-1:0] flags, enables, flg_set, flg_clr;
  logic             unused_addr;

  assign reg_idx     = addr_i[IDX_MSB:IDX_LSB];
  assign unused_addr = ^addr_i;
  assign wr          = cs_i & we_i;
  assign rd          = cs_i & ~we_i;

  for (genvar g = 0; g < NREG; g++) begin : g_store
    if (is_plain(4'(g))) begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      store_q[g] <= '0;
        else if (wr && reg_idx == 4'(g)) store_q[g] <= wdata_i;
      end
    end else begin : g_none
      assign store_q[g] = '0;
    end
  end

  assign t1_cont = (store_q[RI_AUX][7:6] == 2'b01);

  tmr_reload u_t1 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .cont_i      (t1_cont),
    .lat_lo_we_i (wr && (reg_idx == RI_T1CL || reg_idx == RI_T1LL)),
    .lat_hi_we_i (wr && (reg_idx == RI_T1CH || reg_idx == RI_T1LH)),
    .load_we_i   (wr && reg_idx == RI_T1CH),
    .wdata_i     (wdata_i),
    .cnt_o       (t1_cnt),
    .latch_o     (t1_latch),
    .expire_o    (t1_exp)
  );

  tmr_oneshot u_t2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .lo_we_i (wr && reg_idx == RI_T2L),
    .hi_we_i (wr && reg_idx == RI_T2H),
    .wdata_i (wdata_i),
    .cnt_o   (t2_cnt),
    .under_o (t2_under)
  );

  always_comb begin
    flg_set           = '0;
    flg_set[FB_T1]    = t1_exp;
    flg_set[FB_T2]    = t2_under;
    flg_set[FB_SHIFT] = sr_event_i;
    flg_clr           = '0;
    if (wr && reg_idx == RI_FLAG) flg_clr = wdata_i[FLG_W-1:0];
    if ((rd && reg_idx == RI_T1CL) ||
        (wr && (reg_idx == RI_T1CH || reg_idx == RI_T1LH))) flg_clr[FB_T1] = 1'b1;
    if (rd && reg_idx == RI_T2L)   flg_clr[FB_T2]    = 1'b1;
    if (rd && reg_idx == RI_SHIFT) flg_clr[FB_SHIFT] = 1'b1;
  end

  irq_flags u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (flg_set),
    .clr_i     (flg_clr),
    .ena_we_i  (wr && reg_idx == RI_ENA),
    .wdata_i   (wdata_i),
    .flags_o   (flags),
    .enables_o (enables),
    .irq_o     (irq_o)
  );

  always_comb begin
    case (reg_idx)
      RI_T1CL: rdata_o = t1_cnt[BYTE_W-1:0];
      RI_T1CH: rdata_o = t1_cnt[TMR_W-1:BYTE_W];
      RI_T1LL: rdata_o = t1_latch[BYTE_W-1:0];
      RI_T1LH: rdata_o = t1_latch[TMR_W-1:BYTE_W];
      RI_T2L:  rdata_o = t2_cnt[BYTE_W-1:0];
      RI_T2H:  rdata_o = t2_cnt[TMR_W-1:BYTE_W];
      RI_FLAG: rdata_o = {|(flags & enables), flags};
      RI_ENA:  rdata_o = {1'b1, enables};
      default: rdata_o = store_q[reg_idx];
    endcase
  end

endmodule

// File: rtl/tmr_irq_regs_chk.sv
module tmr_irq_regs_chk
  import tmr_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             sr_event_i,
  input logic             cs_i,
  input logic             we_i,
  input logic [3:0]       idx,
  input logic [7:0]       wdata_i,
  input logic [FLG_W-1:0] flg,
  input logic [FLG_W-1:0] ena,
  input logic             irq_o,
  input logic [TMR_W-1:0] t1_cnt,
  input logic [TMR_W-1:0] t1_latch,
  input logic [TMR_W-1:0] t2_cnt,
  input logic             t1_cont
);

  a_r5_flag_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && idx == RI_FLAG && wdata_i[FB_SHIFT] && !sr_event_i) |=> !flg[FB_SHIFT]);

  a_r4_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && idx == RI_ENA && wdata_i[7])
      |=> ((ena & $past(wdata_i[FLG_W-1:0])) == $past(wdata_i[FLG_W-1:0])));

  a_r6_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena[FB_T1] && !ena[FB_SHIFT]) |-> !irq_o);

  a_r8_t1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && idx == RI_T1CH) |=> (t1_cnt == {$past(wdata_i), $past(t1_latch[7:0])}));

  a_r9_t1_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && tick_i && t1_cont && t1_cnt == 16'hFFFF) |=> (t1_cnt == $past(t1_latch)));

  a_r12_t2_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && tick_i) |=> (t2_cnt == $past(t2_cnt) - 16'd1));

  a_r13_shift_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_event_i |=> flg[FB_SHIFT]);

endmodule

bind tmr_irq_regs tmr_irq_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .sr_event_i (sr_event_i),
  .cs_i       (cs_i),
  .we_i       (we_i),
  .idx        (reg_idx),
  .wdata_i    (wdata_i),
  .flg        (flags),
  .ena        (enables),
  .irq_o      (irq_o),
  .t1_cnt     (t1_cnt),
  .t1_latch   (t1_latch),
  .t2_cnt     (t2_cnt),
  .t1_cont    (t1_cont)
);

// File: tb/tmr_irq_regs_bench.sv
module tmr_irq_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 13;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              sr_event_i = 1'b0;
  logic              cs_i = 1'b0;
  logic              we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic [7:0]        rdata_o;
  logic              irq_o;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_regs u_tmr_irq_regs (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .sr_event_i(sr_event_i),
    .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int idx, input int d, input int junk = 0);
    cs_i = 1'b1; we_i = 1'b1;
    addr_i = ADDR_W'((idx << 9) | (junk & 9'h1FF));
    wdata_i = 8'(d);
    @(negedge clk);
    cs_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input int idx, output int d, input int junk = 0);
    cs_i = 1'b1; we_i = 1'b0;
    addr_i = ADDR_W'((idx << 9) | (junk & 9'h1FF));
    #1 d = int'(rdata_o);
    @(negedge clk);
    cs_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic sr_pulse();
    sr_event_i = 1'b1;
    @(negedge clk);
    sr_event_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    int plain_idx[8] = '{0, 1, 2, 3, 10, 11, 12, 15};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      int e;
      rd(i, v);
      e = (i >= 4 && i <= 9) ? 8'hFF : (i == 14 ? 8'h80 : 0);
      check($sformatf("R1 reg %0d", i), v, e);
    end
    check("R1 irq", int'(irq_o), 0);

    // R2 plain registers with varied low address bits
    for (int i = 0; i < 8; i++) wr(plain_idx[i], 8'h11 * (i + 1) ^ 8'h2C, 37 * i + 5);
    for (int i = 0; i < 8; i++) begin
      rd(plain_idx[i], v, 91 * i + 3);
      check($sformatf("R2 reg %0d", plain_idx[i]), v, (8'h11 * (i + 1) ^ 8'h2C) & 8'hFF);
    end
    wr(11, 0);

    // R9 continuous timer 1 sweep over latch 0..15
    wr(11, 8'h40);
    for (int l = 0; l < 16; l++) begin
      wr(13, 8'h7F);
      wr(4, l);
      wr(5, 0);
      rd(4, v);
      check($sformatf("R8 load cnt L=%0d", l), v, l);
      ticks(l);
      rd(13, v);
      check($sformatf("R9 first pre L=%0d", l), v, 0);
      ticks(1);
      rd(13, v);
      check($sformatf("R9 first flag L=%0d", l), v, 8'h40);
      wr(13, 8'h40);
      ticks(l + 1);
      rd(13, v);
      check($sformatf("R9 period pre L=%0d", l), v, 0);
      ticks(1);
      rd(13, v);
      check($sformatf("R9 period flag L=%0d", l), v, 8'h40);
    end

    // R7 read of index 4 clears T1 flag
    rd(4, v);
    rd(13, v);
    check("R7 t1 read clear", v, 0);

    // R8 latch-high write clears flag, no counter load
    wr(4, 2); wr(5, 0);
    ticks(3);
    rd(13, v);
    check("R8 flag set", v, 8'h40);
    wr(7, 8'h12);
    rd(13, v);
    check("R8 latch hi clears flag", v, 0);
    rd(5, v);
    check("R8 counter hi untouched", v, 8'hFF);
    rd(7, v);
    check("R8 latch hi", v, 8'h12);
    wr(6, 8'h34);
    rd(6, v);
    check("R8 latch lo", v, 8'h34);
    rd(5, v);
    check("R8 lo write no load", v, 8'hFF);

    // R10 non-continuous mode
    wr(11, 8'h00);
    wr(13, 8'h7F);
    wr(4, 3); wr(5, 0);
    ticks(4);
    rd(5, v);
    check("R10 reach -1 hi", v, 8'hFF);
    ticks(1);
    rd(4, v);
    check("R10 no reload lo", v, 8'hFE);
    rd(13, v);
    check("R10 no flag", v, 0);
    wr(11, 8'hC0);
    wr(4, 0); wr(5, 0);
    ticks(3);
    rd(13, v);
    check("R10 mode 11 no flag", v, 0);
    wr(11, 8'h00);

    // R11/R12 timer 2 sweep
    for (int n = 1; n <= 8; n++) begin
      wr(13, 8'h7F);
      wr(8, n);
      rd(8, v);
      check($sformatf("R11 low load n=%0d", n), v, n);
      wr(9, 0);
      ticks(n);
      rd(13, v);
      check($sformatf("R12 pre n=%0d", n), v, 0);
      ticks(1);
      rd(13, v);
      check($sformatf("R12 flag n=%0d", n), v, 8'h20);
      rd(8, v);
      check($sformatf("R12 wrap n=%0d", n), v, 8'hFF);
      rd(13, v);
      check($sformatf("R7 t2 read clear n=%0d", n), v, 0);
    end
    wr(8, 8'h5A);
    wr(9, 8'h03);
    rd(9, v);
    check("R11 high join", v, 8'h03);
    rd(8, v);
    check("R11 low kept", v, 8'h5A);
    ticks(5);
    rd(8, v);
    check("R12 decrement", v, 8'h55);
    // R12 second wrap raises nothing
    wr(8, 1); wr(9, 0);
    ticks(2);
    rd(8, v);
    ticks(65536);
    rd(13, v);
    check("R12 no second flag", v, 0);
    rd(9, v);
    check("R12 full wrap", v, 8'hFF);

    // R4/R6/R3 enables and interrupt line
    wr(14, 8'hE0);
    rd(14, v);
    check("R4 enable set", v, 8'hE0);
    wr(8, 0); wr(9, 0);
    ticks(1);
    #1 check("R6 t2 excluded", int'(irq_o), 0);
    rd(13, v);
    check("R3 summary bit", v, 8'hA0);
    sr_pulse();
    #1 check("R6 shift not enabled", int'(irq_o), 0);
    wr(14, 8'h84);
    #1 check("R6 shift enabled", int'(irq_o), 1);
    rd(13, v);
    check("R13 shift flag", v, 8'hA4);
    wr(14, 8'h04);
    #1 check("R6 shift disabled", int'(irq_o), 0);
    rd(14, v);
    check("R4 enable clear", v, 8'hE0);
    wr(14, 8'h84);
    rd(10, v);
    rd(13, v);
    check("R7 shift read clear", v, 8'hA0);
    #1 check("R6 low after clear", int'(irq_o), 0);

    // R13 set wins over same-cycle clear
    cs_i = 1'b1; we_i = 1'b1; addr_i = ADDR_W'(13 << 9); wdata_i = 8'h04; sr_event_i = 1'b1;
    @(negedge clk);
    cs_i = 1'b0; we_i = 1'b0; sr_event_i = 1'b0;
    rd(13, v);
    check("R13 set beats clear", v, 8'hA4);

    // R5 flag write clears selected bits only
    wr(13, 8'h20);
    rd(13, v);
    check("R5 partial clear", v, 8'h84);
    wr(13, 8'h7F);
    rd(13, v);
    check("R5 full clear", v, 0);
    #1 check("R6 idle", int'(irq_o), 0);

    // R6 timer 1 drives line
    wr(11, 8'h40);
    wr(14, 8'hC0);
    wr(4, 1); wr(5, 0);
    ticks(2);
    #1 check("R6 t1 irq", int'(irq_o), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule